// File: doc/BRIEF.md
# Prioritized 64-Source Interrupt Controller

This block collects 64 level-sensitive interrupt request lines, takes them through a two-flop synchronizer into a pending register, and selects one source to present to a processor. Each source has an 8-bit control byte. A nonzero control byte enables the source and also sets its priority. A source can win only when it is pending or forced, enabled, and not masked. The winner's control byte appears on the level output and its vector appears on the vector output.

Software reaches the controller through a simple byte-addressed register bus. The bus has an address, write data, a write strobe and combinational read data. Through it software reads the pending lines and reads or writes the mask and force words in 32-bit halves. It also programs the control bytes, sets or clears single mask bits (or all of them) with one command write, and reads back the current vector from an acknowledge offset. Arbitration is combinational over the registered state, so the outputs follow a register write in the same cycle the write takes effect.

Top module: `intc_prio64`

## Requirements
- R1: After reset the level output is 0 and the vector output is 24. Both mask halves read 0xFFFFFFFF. The pending and force halves read 0, and every control byte reads 0.
- R2: The pending word follows `irq_req` two rising clock edges after a change. It reads at 0x00 (bits 63:32) and 0x04 (bits 31:0). Writes to 0x00 and 0x04 leave it unchanged.
- R3: The mask word is written and read in halves: 0x08 holds bits 63:32 and 0x0C holds bits 31:0. A mask bit of 1 blocks its source.
- R4: The force word is written and read in halves: 0x10 holds bits 63:32 and 0x14 holds bits 31:0. A force bit makes its source pending-equivalent.
- R5: Source n has a control byte at offset 0x40+n, taken from write data bits 7:0 and read back zero-extended. A nonzero byte enables the source and a zero byte disables it.
- R6: A source is active when it is pending or forced, and enabled, and unmasked. Only active sources take part in arbitration.
- R7: Among active sources the largest control byte wins. When control bytes are equal, the source with the higher index wins.
- R8: The level output equals the winner's control byte and the vector output equals the winner index plus 64. With no active source the level is 0 and the vector is 24.
- R9: A write to 0x1C sets the mask bit selected by data bits 5:0. If data bit 6 is 1, all 64 mask bits are set instead.
- R10: A write to 0x1D clears the mask bit selected by data bits 5:0. If data bit 6 is 1, all 64 mask bits are cleared instead.
- R11: A read at 0xE0 returns the current vector. Reads at 0xE1 to 0xE7 return 0, as do reads at any offset that is not mapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 64 | Level-sensitive request lines, one per source |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq_level | output | 8 | Priority level of the winning source, 0 when idle |
| irq_vector | output | 8 | Winner index plus 64, or 24 when idle |

## Verification
A register write takes effect at the rising edge where `bus_we` is high. The level, vector and read data then reflect it in the same cycle, so the bench samples one time unit after that edge. A change on `irq_req` passes through two flops, so it reaches the pending word and the outputs only after the second rising edge. The bench checks the pending word after one edge, where it must still be old, and again after the second edge. Read data is combinational, so each read samples one time unit after the address is set, away from any clock edge.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam logic [7:0] OFS_PEND_HI = 8'h00;
    localparam logic [7:0] OFS_PEND_LO = 8'h04;
    localparam logic [7:0] OFS_MASK_HI = 8'h08;
    localparam logic [7:0] OFS_MASK_LO = 8'h0C;
    localparam logic [7:0] OFS_FRC_HI  = 8'h10;
    localparam logic [7:0] OFS_FRC_LO  = 8'h14;
    localparam logic [7:0] OFS_MSET    = 8'h1C;
    localparam logic [7:0] OFS_MCLR    = 8'h1D;
    localparam logic [7:0] OFS_CTRL    = 8'h40;
    localparam logic [7:0] OFS_ACK     = 8'hE0;
endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
    parameter int WIDTH  = 64,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] q_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[0] <= '0;
                else        stage_q[0] <= d_in;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q_out = stage_q[STAGES-1];
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter #(
    parameter int NUM_SRC  = 64,
    parameter int CTRL_W   = 8,
    parameter int VEC_W    = 8,
    parameter int VEC_BASE = 64,
    parameter int VEC_SPUR = 24,
    localparam int IDX_W   = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0]             active,
    input  logic [NUM_SRC-1:0][CTRL_W-1:0] ctrl,
    output logic [CTRL_W-1:0]              level,
    output logic [VEC_W-1:0]               vector,
    output logic [IDX_W-1:0]               win_idx,
    output logic                           any_active
);
    logic [CTRL_W-1:0] best_lvl;
    logic [IDX_W-1:0]  best_idx;
    logic              found;

    // Ascending scan with >= so that equal levels resolve to the higher index.
    always_comb begin
        best_lvl = '0;
        best_idx = '0;
        found    = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (active[i] && (ctrl[i] >= best_lvl)) begin
                best_lvl = ctrl[i];
                best_idx = IDX_W'(i);
                found    = 1'b1;
            end
        end
    end

    always_comb begin
        win_idx    = best_idx;
        any_active = found;
        if (found) begin
            level  = best_lvl;
            vector = VEC_W'(VEC_BASE) + VEC_W'(best_idx);
        end else begin
            level  = '0;
            vector = VEC_W'(VEC_SPUR);
        end
    end
endmodule

// File: rtl/intc_regs.sv
module intc_regs
    import intc_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int CTRL_W  = 8,
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32,
    parameter int VEC_W   = 8,
    localparam int IDX_W  = $clog2(NUM_SRC),
    localparam int ALL_BIT = IDX_W
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [ADDR_W-1:0]              bus_addr,
    input  logic [DATA_W-1:0]              bus_wdata,
    input  logic                           bus_we,
    input  logic [NUM_SRC-1:0]             pending,
    input  logic [VEC_W-1:0]               vector,
    output logic [DATA_W-1:0]              bus_rdata,
    output logic [NUM_SRC-1:0]             mask_q,
    output logic [NUM_SRC-1:0]             force_q,
    output logic [NUM_SRC-1:0][CTRL_W-1:0] ctrl_q,
    output logic [NUM_SRC-1:0]             enable
);
    logic             ctrl_hit;
    logic [IDX_W-1:0] ctrl_idx;
    logic [IDX_W-1:0] cmd_idx;
    logic             cmd_all;

    assign ctrl_hit = (bus_addr >= ADDR_W'(OFS_CTRL)) &&
                      (bus_addr <  ADDR_W'(OFS_CTRL) + ADDR_W'(NUM_SRC));
    assign ctrl_idx = IDX_W'(bus_addr - ADDR_W'(OFS_CTRL));
    assign cmd_idx  = bus_wdata[IDX_W-1:0];
    assign cmd_all  = bus_wdata[ALL_BIT];

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_en
        assign enable[i] = |ctrl_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q  <= '1;
            force_q <= '0;
            ctrl_q  <= '0;
        end else if (bus_we) begin
            if (ctrl_hit) begin
                ctrl_q[ctrl_idx] <= bus_wdata[CTRL_W-1:0];
            end else begin
                case (bus_addr)
                    ADDR_W'(OFS_MASK_HI): mask_q[NUM_SRC-1 -: DATA_W] <= bus_wdata;
                    ADDR_W'(OFS_MASK_LO): mask_q[DATA_W-1:0]          <= bus_wdata;
                    ADDR_W'(OFS_FRC_HI):  force_q[NUM_SRC-1 -: DATA_W] <= bus_wdata;
                    ADDR_W'(OFS_FRC_LO):  force_q[DATA_W-1:0]          <= bus_wdata;
                    ADDR_W'(OFS_MSET): begin
                        if (cmd_all) mask_q <= '1;
                        else         mask_q[cmd_idx] <= 1'b1;
                    end
                    ADDR_W'(OFS_MCLR): begin
                        if (cmd_all) mask_q <= '0;
                        else         mask_q[cmd_idx] <= 1'b0;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (ctrl_hit) begin
            bus_rdata = DATA_W'(ctrl_q[ctrl_idx]);
        end else begin
            case (bus_addr)
                ADDR_W'(OFS_PEND_HI): bus_rdata = pending[NUM_SRC-1 -: DATA_W];
                ADDR_W'(OFS_PEND_LO): bus_rdata = pending[DATA_W-1:0];
                ADDR_W'(OFS_MASK_HI): bus_rdata = mask_q[NUM_SRC-1 -: DATA_W];
                ADDR_W'(OFS_MASK_LO): bus_rdata = mask_q[DATA_W-1:0];
                ADDR_W'(OFS_FRC_HI):  bus_rdata = force_q[NUM_SRC-1 -: DATA_W];
                ADDR_W'(OFS_FRC_LO):  bus_rdata = force_q[DATA_W-1:0];
                ADDR_W'(OFS_ACK):     bus_rdata = DATA_W'(vector);
                default:              bus_rdata = '0;
            endcase
        end
    end

    // R9
    mask_set_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(OFS_MSET) && cmd_all) |=> (&mask_q));

    // R9
    mask_set_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(OFS_MSET) && !cmd_all) |=> mask_q[$past(cmd_idx)]);

    // R10
    mask_clr_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(OFS_MCLR) && cmd_all) |=> (mask_q == '0));

    // R10
    mask_clr_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(OFS_MCLR) && !cmd_all) |=> !mask_q[$past(cmd_idx)]);
endmodule

// File: rtl/intc_prio64.sv
module intc_prio64 #(
    parameter int NUM_SRC  = 64,
    parameter int CTRL_W   = 8,
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int VEC_W    = 8,
    parameter int VEC_BASE = 64,
    parameter int VEC_SPUR = 24,
    parameter int SYNC_STAGES = 2,
    localparam int IDX_W   = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_req,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    input  logic               bus_we,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic [CTRL_W-1:0]  irq_level,
    output logic [VEC_W-1:0]   irq_vector
);
    logic [NUM_SRC-1:0]             pending;
    logic [NUM_SRC-1:0]             mask_q;
    logic [NUM_SRC-1:0]             force_q;
    logic [NUM_SRC-1:0]             enable;
    logic [NUM_SRC-1:0][CTRL_W-1:0] ctrl_q;
    logic [NUM_SRC-1:0]             active;
    logic [IDX_W-1:0]               win_idx;
    logic                           any_active;

    intc_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (irq_req),
        .q_out (pending)
    );

    intc_regs #(
        .NUM_SRC(NUM_SRC), .CTRL_W(CTRL_W), .ADDR_W(ADDR_W),
        .DATA_W(DATA_W), .VEC_W(VEC_W)
    ) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .pending   (pending),
        .vector    (irq_vector),
        .bus_rdata (bus_rdata),
        .mask_q    (mask_q),
        .force_q   (force_q),
        .ctrl_q    (ctrl_q),
        .enable    (enable)
    );

    assign active = (pending | force_q) & enable & ~mask_q;

    intc_arbiter #(
        .NUM_SRC(NUM_SRC), .CTRL_W(CTRL_W), .VEC_W(VEC_W),
        .VEC_BASE(VEC_BASE), .VEC_SPUR(VEC_SPUR)
    ) arb_i (
        .active     (active),
        .ctrl       (ctrl_q),
        .level      (irq_level),
        .vector     (irq_vector),
        .win_idx    (win_idx),
        .any_active (any_active)
    );

    // R8
    spurious_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !any_active |-> (irq_level == '0 && irq_vector == VEC_W'(VEC_SPUR)));

    // R6
    winner_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_active |-> (active[win_idx] && irq_level != '0));

    // R7
    winner_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_active |-> (irq_level == ctrl_q[win_idx]));
endmodule

// File: tb/intc_prio64_tb.sv
module intc_prio64_tb_top;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] irq_req = '0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_rdata;
    logic [7:0]  irq_level;
    logic [7:0]  irq_vector;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    logic [63:0] m_mask;
    logic [63:0] m_force;
    logic [63:0] m_pend;
    logic [7:0]  m_ctrl [64];

    always #(CLK_P/2) clk = ~clk;

    intc_prio64 dut_i (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
        .bus_rdata(bus_rdata), .irq_level(irq_level), .irq_vector(irq_vector)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic void model_out(output logic [7:0] lvl, output logic [7:0] vec);
        logic [63:0] act;
        lvl = 8'd0;
        vec = 8'd24;
        for (int i = 0; i < 64; i++) begin
            act[i] = (m_pend[i] | m_force[i]) & (m_ctrl[i] != 0) & ~m_mask[i];
            if (act[i] && m_ctrl[i] >= lvl) begin
                lvl = m_ctrl[i];
                vec = 8'(64 + i);
            end
        end
    endfunction

    task automatic check_outputs(input string tag);
        logic [7:0] el, ev;
        model_out(el, ev);
        check({tag, " level"}, 64'(irq_level), 64'(el));
        check({tag, " vector"}, 64'(irq_vector), 64'(ev));
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk);
        #1;
        bus_we = 1'b0;
        if (a >= 8'h40 && a < 8'h80) m_ctrl[a - 8'h40] = d[7:0];
        else case (a)
            8'h08: m_mask[63:32] = d;
            8'h0C: m_mask[31:0]  = d;
            8'h10: m_force[63:32] = d;
            8'h14: m_force[31:0]  = d;
            8'h1C: if (d[6]) m_mask = '1; else m_mask[d[5:0]] = 1'b1;
            8'h1D: if (d[6]) m_mask = '0; else m_mask[d[5:0]] = 1'b0;
            default: ;
        endcase
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic set_req(input logic [63:0] r);
        @(negedge clk);
        irq_req = r;
        @(posedge clk); @(posedge clk);
        #1;
        m_pend = r;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        bus_read(8'h08, d); check("R1 mask hi", 64'(d), 64'hFFFF_FFFF);
        bus_read(8'h0C, d); check("R1 mask lo", 64'(d), 64'hFFFF_FFFF);
        bus_read(8'h00, d); check("R1 pend hi", 64'(d), 0);
        bus_read(8'h14, d); check("R1 force lo", 64'(d), 0);
        bus_read(8'h45, d); check("R1 ctrl5", 64'(d), 0);
        check("R1 level", 64'(irq_level), 0);
        check("R1 vector", 64'(irq_vector), 24);
    endtask

    task automatic t_ctrl();
        logic [31:0] d;
        bus_write(8'h43, 32'hFFFF_FF05);
        bus_read(8'h43, d); check("R5 ctrl readback", 64'(d), 64'h05);
        bus_write(8'h43, 32'h0);
        bus_read(8'h43, d); check("R5 ctrl zero", 64'(d), 0);
    endtask

    task automatic t_pending();
        logic [31:0] d;
        logic [63:0] r;
        r = 64'h0000_0100_0000_0004;
        @(negedge clk);
        irq_req = r;
        @(posedge clk); #1;
        bus_read(8'h04, d); check("R2 pend one edge", 64'(d), 0);
        @(posedge clk); #1;
        m_pend = r;
        bus_read(8'h00, d); check("R2 pend hi", 64'(d), 64'h100);
        bus_read(8'h04, d); check("R2 pend lo", 64'(d), 64'h4);
        bus_write(8'h00, 32'hFFFF_FFFF);
        bus_write(8'h04, 32'h0);
        bus_read(8'h00, d); check("R2 pend hi write ignored", 64'(d), 64'h100);
        bus_read(8'h04, d); check("R2 pend lo write ignored", 64'(d), 64'h4);
        set_req('0);
    endtask

    task automatic t_mask_halves();
        logic [31:0] d;
        bus_write(8'h08, 32'hA5A5_0F0F);
        bus_write(8'h0C, 32'h1234_5678);
        bus_read(8'h08, d); check("R3 mask hi", 64'(d), 64'hA5A5_0F0F);
        bus_read(8'h0C, d); check("R3 mask lo", 64'(d), 64'h1234_5678);
        bus_write(8'h08, 32'hFFFF_FFFF);
        bus_write(8'h0C, 32'hFFFF_FFFF);
    endtask

    task automatic t_arbitrate();
        logic [31:0] d;
        bus_write(8'h43, 5); bus_write(8'h4A, 5);
        bus_write(8'h54, 2); bus_write(8'h68, 7);
        set_req((64'd1 << 3) | (64'd1 << 10) | (64'd1 << 20));
        check_outputs("R6 all masked");
        check("R3 masked idle vector", 64'(irq_vector), 24);
        bus_write(8'h1D, 3); bus_write(8'h1D, 10); bus_write(8'h1D, 20);
        check_outputs("R7 tie high index");
        check("R7 tie vector", 64'(irq_vector), 74);
        check("R8 tie level", 64'(irq_level), 5);
        bus_read(8'hE0, d); check("R11 ack vector", 64'(d), 74);
        bus_write(8'h1C, 10);
        check("R9 set one mask", 64'(irq_vector), 67);
        check_outputs("R9 model");
        bus_write(8'h1D, 40);
        set_req(m_pend | (64'd1 << 40));
        check("R8 level 7", 64'(irq_level), 7);
        check("R8 vector 104", 64'(irq_vector), 104);
        bus_write(8'h68, 0);
        check("R5 disabled by zero", 64'(irq_vector), 67);
        check_outputs("R5 model");
        bus_write(8'h43, 1);
        check("R7 lower level loses", 64'(irq_vector), 84);
        check_outputs("R7 model");
    endtask

    task automatic t_force();
        logic [31:0] d;
        set_req('0);
        check_outputs("R8 idle");
        check("R8 idle vector", 64'(irq_vector), 24);
        bus_write(8'h54, 9);
        bus_write(8'h14, 32'h0010_0000);
        bus_write(8'h10, 32'h0000_0001);
        bus_read(8'h14, d); check("R4 force lo", 64'(d), 64'h0010_0000);
        bus_read(8'h10, d); check("R4 force hi", 64'(d), 64'h1);
        check("R4 forced winner", 64'(irq_vector), 84);
        check("R4 forced level", 64'(irq_level), 9);
        bus_write(8'h14, 0); bus_write(8'h10, 0);
        check_outputs("R4 unforced");
    endtask

    task automatic t_mask_all();
        logic [31:0] d;
        bus_write(8'h14, 32'h0000_0408);
        bus_write(8'h1C, 32'h40);
        bus_read(8'h08, d); check("R9 all set hi", 64'(d), 64'hFFFF_FFFF);
        bus_read(8'h0C, d); check("R9 all set lo", 64'(d), 64'hFFFF_FFFF);
        check("R9 all masked vector", 64'(irq_vector), 24);
        bus_write(8'h1D, 32'h40);
        bus_read(8'h08, d); check("R10 all clr hi", 64'(d), 0);
        bus_read(8'h0C, d); check("R10 all clr lo", 64'(d), 0);
        check_outputs("R10 unmasked winner");
        check("R10 vector", 64'(irq_vector), 74);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        for (int a = 8'hE1; a <= 8'hE7; a++) begin
            bus_read(8'(a), d); check("R11 level ack zero", 64'(d), 0);
        end
        bus_read(8'h18, d); check("R11 unmapped 18", 64'(d), 0);
        bus_read(8'h1C, d); check("R11 unmapped 1C", 64'(d), 0);
        bus_read(8'hF0, d); check("R11 unmapped F0", 64'(d), 0);
    endtask

    initial begin
        m_mask = '1; m_force = '0; m_pend = '0;
        for (int i = 0; i < 64; i++) m_ctrl[i] = 8'd0;
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_ctrl();
        t_pending();
        t_mask_halves();
        t_arbitrate();
        t_force();
        t_mask_all();
        t_unmapped();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule